// File: doc/BRIEF.md
# Processor Status Flag and Interrupt Level Register

This block is the status byte of a small 8-bit processor core. It stores four result flags (carry, zero, negative, half carry) and a two-bit code for the current interrupt priority level. Each cycle it takes the class of the operation just executed, the ALU result and its carry signals, and a set of command strobes. From these it works out the next value and captures it on the clock edge. The instruction decoder, the ALU and the stack all sit outside the block.

The interrupt level code is not a plain binary number. Code 10 is level 0, which is the main program. Code 01 is level 1, code 00 is level 2, and code 11 is level 3, at which all maskable requests are blocked. When an interrupt is taken, the code is loaded from the priority programmed for that source. The block also decides, combinationally, whether a pending request of a given level may be taken now.

Top module: `psw_ctrl`

## Requirements
- R1: After reset the register reads 8'hE8: both interrupt bits are 1 and all four result flags are 0.
- R2: Bit positions are fixed as follows: I1 at bit 5, H at bit 4, I0 at bit 3, N at bit 2, Z at bit 1 and C at bit 0. Bits 7 and 6 always read 1, even after a restore that writes 0 to them.
- R3: Operation class 3'd1 (add or add-with-carry) loads H from the bit-3 carry and C from the bit-7 carry. It sets N to result bit 7, and sets Z when the result is zero.
- R4: Operation class 3'd2 (other arithmetic) updates N, Z and C (C from the bit-7 carry/borrow). It leaves H unchanged.
- R5: Operation classes 3'd3 (logic) and 3'd6 (data move) update N and Z only. H and C are left unchanged.
- R6: Operation class 3'd4 (shift or rotate) loads C from the shift-out bit and updates N and Z. Class 3'd5 (bit test and branch) loads C from the shift-out bit and leaves H, N and Z unchanged.
- R7: The set-carry strobe forces C to 1 and the clear-carry strobe forces C to 0. Set wins over clear, and both win over any carry value from the operation in the same cycle.
- R8: The mask strobe writes the interrupt code 11. The unmask strobe writes 10. Halt/wait entry writes 10.
- R9: Interrupt entry loads the interrupt code from irq_prio. When several strobes act in one cycle, the order is: entry first, then mask, then unmask, then halt.
- R10: Restore loads bits 5..0 from restore_val in one cycle and overrides every other update made in that cycle.
- R11: req_accept is 1 only when req_valid is 1 and req_level (binary, 0 to 3) is strictly greater than the decoded current level. It is therefore never 1 at level 3.
- R12: Operation class 3'd0 with no strobe active leaves the register unchanged, whatever the ALU inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_class | input | 3 | Class of the completed operation |
| alu_res | input | 8 | ALU result byte |
| carry_b3 | input | 1 | Carry out of bit 3 |
| carry_b7 | input | 1 | Carry or borrow out of bit 7 |
| shift_out | input | 1 | Bit shifted out or tested |
| set_c | input | 1 | Force carry to 1 |
| clr_c | input | 1 | Force carry to 0 |
| set_mask | input | 1 | Write interrupt code 11 |
| clr_mask | input | 1 | Write interrupt code 10 |
| irq_enter | input | 1 | Interrupt entry strobe |
| irq_prio | input | 2 | Programmed code of the interrupting source |
| restore | input | 1 | Full-byte restore strobe |
| restore_val | input | 8 | Byte to restore |
| halt_enter | input | 1 | Halt or wait entry strobe |
| req_valid | input | 1 | A request is pending |
| req_level | input | 2 | Binary level of the pending request |
| psw | output | 8 | Register value |
| req_accept | output | 1 | Pending request may be taken |

## Verification
Several updates can land in the same cycle: a forced carry together with an operation that would write its own carry, interrupt entry together with mask or unmask, and a restore together with both a carry strobe and interrupt entry. The bench drives each of these combinations on a single clock edge. A scoreboard model then checks that the winning source alone sets the affected bits. Acceptance is checked straight after each level change, with requests just above and exactly at the new level.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    OPC_NONE  = 3'd0,
    OPC_ADD   = 3'd1,
    OPC_ARITH = 3'd2,
    OPC_LOGIC = 3'd3,
    OPC_SHIFT = 3'd4,
    OPC_BTST  = 3'd5,
    OPC_MOVE  = 3'd6
  } opc_e;

  localparam int unsigned POS_C  = 0;
  localparam int unsigned POS_Z  = 1;
  localparam int unsigned POS_N  = 2;
  localparam int unsigned POS_I0 = 3;
  localparam int unsigned POS_H  = 4;
  localparam int unsigned POS_I1 = 5;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic c;
  } rflags_t;

  localparam logic [1:0] CODE_MASKED = 2'b11;
  localparam logic [1:0] CODE_MAIN   = 2'b10;
endpackage

// File: rtl/psw_rst_sync.sv
module psw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/psw_result_flags.sv
module psw_result_flags
  import psw_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [2:0] op_class,
  input  logic [W-1:0] res,
  input  logic       c3,
  input  logic       c7,
  input  logic       sh,
  input  logic       force_set,
  input  logic       force_clr,
  input  rflags_t    cur,
  output rflags_t    nxt,
  output logic       touched
);
  localparam int unsigned MSB = W - 1;

  logic res_neg;
  logic res_zero;
  logic op_c;
  opc_e opc;

  assign opc      = opc_e'(op_class);
  assign res_neg  = res[MSB];
  assign res_zero = ~|res;

  always_comb begin
    nxt     = cur;
    op_c    = cur.c;
    touched = 1'b0;
    unique case (opc)
      OPC_ADD: begin
        nxt.h   = c3;
        nxt.n   = res_neg;
        nxt.z   = res_zero;
        op_c    = c7;
        touched = 1'b1;
      end
      OPC_ARITH: begin
        nxt.n   = res_neg;
        nxt.z   = res_zero;
        op_c    = c7;
        touched = 1'b1;
      end
      OPC_LOGIC, OPC_MOVE: begin
        nxt.n   = res_neg;
        nxt.z   = res_zero;
        touched = 1'b1;
      end
      OPC_SHIFT: begin
        nxt.n   = res_neg;
        nxt.z   = res_zero;
        op_c    = sh;
        touched = 1'b1;
      end
      OPC_BTST: begin
        op_c    = sh;
        touched = 1'b1;
      end
      default: begin
        touched = 1'b0;
      end
    endcase

    if (force_set) begin
      nxt.c = 1'b1;
    end else if (force_clr) begin
      nxt.c = 1'b0;
    end else begin
      nxt.c = op_c;
    end
    touched = touched | force_set | force_clr;
  end
endmodule

// File: rtl/psw_level_ctrl.sv
module psw_level_ctrl
  import psw_pkg::*;
(
  input  logic [1:0] cur_code,
  input  logic       irq_enter,
  input  logic [1:0] irq_prio,
  input  logic       set_mask,
  input  logic       clr_mask,
  input  logic       halt_enter,
  input  logic       req_valid,
  input  logic [1:0] req_level,
  output logic [1:0] nxt_code,
  output logic       touched,
  output logic       accept
);
  logic [1:0] cur_level;

  // Code to binary level: 10->0, 01->1, 00->2, 11->3
  assign cur_level = {~(cur_code[1] ^ cur_code[0]), cur_code[0]};

  always_comb begin
    nxt_code = cur_code;
    if (irq_enter) begin
      nxt_code = irq_prio;
    end else if (set_mask) begin
      nxt_code = CODE_MASKED;
    end else if (clr_mask) begin
      nxt_code = CODE_MAIN;
    end else if (halt_enter) begin
      nxt_code = CODE_MAIN;
    end
  end

  assign touched = irq_enter | set_mask | clr_mask | halt_enter;
  assign accept  = req_valid & (req_level > cur_level);
endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_class,
  input  logic [W-1:0] alu_res,
  input  logic         carry_b3,
  input  logic         carry_b7,
  input  logic         shift_out,
  input  logic         set_c,
  input  logic         clr_c,
  input  logic         set_mask,
  input  logic         clr_mask,
  input  logic         irq_enter,
  input  logic [1:0]   irq_prio,
  input  logic         restore,
  input  logic [W-1:0] restore_val,
  input  logic         halt_enter,
  input  logic         req_valid,
  input  logic [1:0]   req_level,
  output logic [W-1:0] psw,
  output logic         req_accept
);
  localparam int unsigned PAD_W = W - 6;

  logic       srst_n;
  rflags_t    flags_q, flags_d, flags_op;
  logic [1:0] code_q, code_d, code_op;
  logic       flag_touch, lvl_touch, upd_en;
  logic       unused_rv;

  psw_rst_sync u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  psw_result_flags #(.W(W)) u_flags (
    .op_class  (op_class),
    .res       (alu_res),
    .c3        (carry_b3),
    .c7        (carry_b7),
    .sh        (shift_out),
    .force_set (set_c),
    .force_clr (clr_c),
    .cur       (flags_q),
    .nxt       (flags_op),
    .touched   (flag_touch)
  );

  psw_level_ctrl u_lvl (
    .cur_code   (code_q),
    .irq_enter  (irq_enter),
    .irq_prio   (irq_prio),
    .set_mask   (set_mask),
    .clr_mask   (clr_mask),
    .halt_enter (halt_enter),
    .req_valid  (req_valid),
    .req_level  (req_level),
    .nxt_code   (code_op),
    .touched    (lvl_touch),
    .accept     (req_accept)
  );

  assign unused_rv = ^restore_val[W-1:6];

  // Next-state selection: restore overrides every other source
  always_comb begin
    if (restore) begin
      flags_d.h = restore_val[POS_H];
      flags_d.n = restore_val[POS_N];
      flags_d.z = restore_val[POS_Z];
      flags_d.c = restore_val[POS_C];
      code_d    = {restore_val[POS_I1], restore_val[POS_I0]};
    end else begin
      flags_d   = flags_op;
      code_d    = code_op;
    end
  end

  assign upd_en = restore | flag_touch | lvl_touch;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      flags_q <= '0;
      code_q  <= CODE_MASKED;
    end else if (upd_en) begin
      flags_q <= flags_d;
      code_q  <= code_d;
    end
  end

  assign psw = {{PAD_W{1'b1}}, code_q[1], flags_q.h, code_q[0],
                flags_q.n, flags_q.z, flags_q.c};
endmodule

// File: rtl/psw_chk.sv
module psw_chk (
  input logic       clk,
  input logic       srst_n,
  input logic [2:0] op_class,
  input logic       carry_b3,
  input logic       set_c,
  input logic       set_mask,
  input logic       clr_mask,
  input logic       irq_enter,
  input logic [1:0] irq_prio,
  input logic       restore,
  input logic [7:0] restore_val,
  input logic       halt_enter,
  input logic       clr_c,
  input logic [7:0] psw,
  input logic       req_accept
);
  // R2: padding bits read 1
  a_r2_pad_ones: assert property (@(posedge clk) disable iff (!srst_n)
    psw[7:6] == 2'b11);

  // R3: add class loads H from the bit-3 carry
  a_r3_half_carry: assert property (@(posedge clk) disable iff (!srst_n)
    (op_class == 3'd1 && !restore) |=> psw[4] == $past(carry_b3));

  // R7: set-carry wins
  a_r7_set_carry: assert property (@(posedge clk) disable iff (!srst_n)
    (set_c && !restore) |=> psw[0]);

  // R8: mask command gives code 11
  a_r8_mask: assert property (@(posedge clk) disable iff (!srst_n)
    (set_mask && !irq_enter && !restore) |=> (psw[5] && psw[3]));

  // R9: entry loads programmed code
  a_r9_entry: assert property (@(posedge clk) disable iff (!srst_n)
    (irq_enter && !restore) |=> {psw[5], psw[3]} == $past(irq_prio));

  // R10: restore overrides every other source
  a_r10_restore: assert property (@(posedge clk) disable iff (!srst_n)
    restore |=> psw[5:0] == $past(restore_val[5:0]));

  // R11: nothing accepted at level 3
  a_r11_masked: assert property (@(posedge clk) disable iff (!srst_n)
    (psw[5] && psw[3]) |-> !req_accept);

  // R12: idle cycle holds the value
  a_r12_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (op_class == 3'd0 && !set_c && !clr_c && !set_mask && !clr_mask &&
     !irq_enter && !restore && !halt_enter) |=> $stable(psw));
endmodule

bind psw_ctrl psw_chk u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .op_class    (op_class),
  .carry_b3    (carry_b3),
  .set_c       (set_c),
  .set_mask    (set_mask),
  .clr_mask    (clr_mask),
  .irq_enter   (irq_enter),
  .irq_prio    (irq_prio),
  .restore     (restore),
  .restore_val (restore_val),
  .halt_enter  (halt_enter),
  .clr_c       (clr_c),
  .psw         (psw),
  .req_accept  (req_accept)
);

// File: tb/tb_psw_ctrl.sv
`timescale 1ns/100ps
module tb_psw_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] op_class;
  logic [7:0] alu_res;
  logic       carry_b3, carry_b7, shift_out;
  logic       set_c, clr_c, set_mask, clr_mask, irq_enter, restore, halt_enter;
  logic [1:0] irq_prio;
  logic [7:0] restore_val;
  logic       req_valid;
  logic [1:0] req_level;
  logic [7:0] psw;
  logic       req_accept;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] psw;
    logic       acc;
  } exp_t;
  exp_t exp_q[$];

  // reference state
  logic m_h, m_n, m_z, m_c;
  logic [1:0] m_code;

  always #2.5 clk = ~clk;

  psw_ctrl dut (
    .clk(clk), .rst_n(rst_n), .op_class(op_class), .alu_res(alu_res),
    .carry_b3(carry_b3), .carry_b7(carry_b7), .shift_out(shift_out),
    .set_c(set_c), .clr_c(clr_c), .set_mask(set_mask), .clr_mask(clr_mask),
    .irq_enter(irq_enter), .irq_prio(irq_prio), .restore(restore),
    .restore_val(restore_val), .halt_enter(halt_enter),
    .req_valid(req_valid), .req_level(req_level),
    .psw(psw), .req_accept(req_accept)
  );

  function automatic int lvl_of(logic [1:0] code);
    case (code)
      2'b10:   return 0;
      2'b01:   return 1;
      2'b00:   return 2;
      default: return 3;
    endcase
  endfunction

  task automatic idle_inputs();
    op_class = 3'd0; alu_res = 8'h00; carry_b3 = 0; carry_b7 = 0; shift_out = 0;
    set_c = 0; clr_c = 0; set_mask = 0; clr_mask = 0; irq_enter = 0;
    irq_prio = 2'b00; restore = 0; restore_val = 8'h00; halt_enter = 0;
  endtask

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual psw=%h acc=%b expected psw=%h acc=%b",
               tag, act[8:1], act[0], exp[8:1], exp[0]);
    end
  endtask

  // Driver: compute expected result of this cycle's stimulus, queue it
  task automatic go(string tag);
    exp_t e;
    logic zero;
    zero = (alu_res == 8'h00);
    if (restore) begin
      m_h = restore_val[4]; m_n = restore_val[2];
      m_z = restore_val[1]; m_c = restore_val[0];
      m_code = {restore_val[5], restore_val[3]};
    end else begin
      case (op_class)
        3'd1: begin m_h = carry_b3; m_n = alu_res[7]; m_z = zero; m_c = carry_b7; end
        3'd2: begin m_n = alu_res[7]; m_z = zero; m_c = carry_b7; end
        3'd3, 3'd6: begin m_n = alu_res[7]; m_z = zero; end
        3'd4: begin m_n = alu_res[7]; m_z = zero; m_c = shift_out; end
        3'd5: m_c = shift_out;
        default: ;
      endcase
      if (set_c) m_c = 1'b1;
      else if (clr_c) m_c = 1'b0;
      if (irq_enter) m_code = irq_prio;
      else if (set_mask) m_code = 2'b11;
      else if (clr_mask) m_code = 2'b10;
      else if (halt_enter) m_code = 2'b10;
    end
    e.tag = tag;
    e.psw = {2'b11, m_code[1], m_h, m_code[0], m_n, m_z, m_c};
    e.acc = req_valid && (int'(req_level) > lvl_of(m_code));
    exp_q.push_back(e);
    @(negedge clk);
    idle_inputs();
  endtask

  // Monitor: compare just after the edge that captured the stimulus
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, {psw, req_accept}, {e.psw, e.acc});
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    req_valid = 0; req_level = 2'd0;
    rst_n = 1'b0;
    m_h = 0; m_n = 0; m_z = 0; m_c = 0; m_code = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset value, R11: level 3 accepts nothing
    req_valid = 1; req_level = 2'd3;
    #0.1;
    check("R1 reset value / R11 level3", {psw, req_accept}, {8'hE8, 1'b0});

    // R3: add with zero result and both carries
    op_class = 3'd1; alu_res = 8'h00; carry_b3 = 1; carry_b7 = 1; go("R3 add zero carries");
    // R3: add negative, no carries
    op_class = 3'd1; alu_res = 8'h85; go("R3 add negative");
    // R4: set H, then arithmetic keeps H
    op_class = 3'd1; alu_res = 8'h10; carry_b3 = 1; go("R3 add half carry");
    op_class = 3'd2; alu_res = 8'h00; carry_b7 = 1; go("R4 arith keeps H");
    // R5: logic keeps C and H
    op_class = 3'd3; alu_res = 8'h80; go("R5 logic N");
    op_class = 3'd6; alu_res = 8'h00; carry_b7 = 0; go("R5 move Z");
    // R6: shift and bit test
    op_class = 3'd4; alu_res = 8'h41; shift_out = 0; go("R6 shift");
    op_class = 3'd5; alu_res = 8'h00; shift_out = 1; go("R6 bit test C only");
    // R7: forced carry beats operation carry
    op_class = 3'd1; alu_res = 8'h02; carry_b7 = 0; set_c = 1; go("R7 set over add");
    op_class = 3'd4; alu_res = 8'h01; shift_out = 1; clr_c = 1; go("R7 clear over shift");
    set_c = 1; clr_c = 1; go("R7 set over clear");
    // R8: unmask, acceptance at level 0
    req_level = 2'd1; clr_mask = 1; go("R8 unmask / R11 lvl1 over 0");
    req_level = 2'd0; go("R11 equal level refused");
    // R9: entry beats mask in same cycle
    req_level = 2'd1; irq_enter = 1; irq_prio = 2'b01; set_mask = 1; go("R9 entry over mask");
    req_level = 2'd2; go("R11 lvl2 over 1");
    irq_enter = 1; irq_prio = 2'b00; clr_mask = 1; go("R9 entry code 00");
    req_level = 2'd3; go("R11 lvl3 over 2");
    // R8: mask, then halt
    set_mask = 1; go("R8 mask");
    halt_enter = 1; go("R8 halt");
    // R10 and R2: restore overrides carry and entry
    restore = 1; restore_val = 8'h00; set_c = 1; irq_enter = 1; irq_prio = 2'b11;
    op_class = 3'd1; alu_res = 8'h80; carry_b3 = 1; go("R10 restore zero / R2 pad");
    restore = 1; restore_val = 8'h3F; clr_mask = 1; go("R10 restore ones");
    // R12: idle with active ALU inputs
    alu_res = 8'h00; carry_b3 = 1; carry_b7 = 1; shift_out = 1; go("R12 idle hold");
    restore = 1; restore_val = 8'h15; go("R10 restore mixed");
    alu_res = 8'hFF; go("R12 idle hold 2");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule